// File: doc/BRIEF.md
# Flash Erase Command Controller

This block sits between a byte-wide bus and a small block-erasable flash array. Writes on the bus carry a command byte and an address. A sequencer decodes them and runs a two-step block erase. The erase can be paused so that another block can be read or programmed, and then continued. Reads on the bus return one of three things, chosen by the last read-mode command: array bytes, an 8-bit status register, or a fixed identification byte.

Errors are reported per cause in the status register and stay set until they are cleared. The cause can be a bad command sequence, a missing programming voltage, or a locked block. A separate busy output lets a host wait for completion without polling the bus. The array is a behavioural register model. An erase lasts a parameterized number of clock cycles and fills the whole target block with FFh. A program lasts a shorter parameterized count.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the status register reads 80h, `sts_busy_o` is 0, reads return array data, and array byte i holds the value i.
- R2: Writing 20h and then D0h selects the block that contains the D0h address. That block becomes all FFh after exactly ERASE_CYCLES busy cycles, and every other block is left unchanged.
- R3: After an erase sequence is written, reads return the status register until another read-mode command is written. FFh selects array data, 70h selects status, and 98h selects the identification byte 51h.
- R4: Status bit 7 is 1 when no erase or program is running and 0 while one runs. `sts_busy_o` is always the inverse of bit 7.
- R5: If the byte written after 20h is not D0h, status bits 5 and 4 are set, no erase starts, and the array is unchanged.
- R6: If `vpp_ok_i` is low at the confirm, status bits 5 and 3 are set and the array is unchanged.
- R7: If the target block's lock bit is 1 and `hv_override_i` is 0 at the confirm, status bits 5 and 1 are set and nothing is erased. If `hv_override_i` is 1, the lock bit is ignored.
- R8: Writing B0h during an erase suspends it at the next clock edge. The status then reads C0h (bits 7 and 6), `sts_busy_o` goes to 0, and the erase counter is kept.
- R9: While suspended, the read-mode commands, clear status (50h) and resume are accepted. A program (40h, then an address/data write) to another block stores the byte after PROG_CYCLES busy cycles. A program aimed at the suspended block sets bit 4 and writes nothing. Any other command, for example 20h, leaves the status unchanged.
- R10: D0h while suspended clears bits 6 and 7 and raises `sts_busy_o`. The erase then runs only the cycles it had left, so the busy time across the suspend adds up to ERASE_CYCLES.
- R11: A D0h written while a program runs during suspend does not end the suspend early. Bit 6 stays 1 until the program finishes, and the erase then continues without a ready gap.
- R12: 50h clears bits 5, 4, 3 and 1 and leaves bits 7 and 6 unchanged. Error bits stay set until 50h is written.
- R13: During an erase, every command other than B0h is ignored, so reads keep returning status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for a command or data byte |
| bus_addr_i | input | ADDR_W | Byte address for writes and reads |
| bus_wdata_i | input | 8 | Command or program data byte |
| bus_rd_i | input | 1 | Read strobe; read data is registered on this cycle |
| bus_rdata_o | output | 8 | Array byte, status register, or identification byte |
| vpp_ok_i | input | 1 | Programming voltage is valid |
| hv_override_i | input | 1 | High-voltage reset-pin override of the block locks |
| blk_lock_i | input | NUM_BLOCKS | Lock bit for each block |
| sts_busy_o | output | 1 | 1 while an erase or program runs |

## Verification
The bench counts busy cycles on either side of a suspend. A design that loses or repeats the suspend cycle's work makes the erase one cycle short or long. It also lets a resume arrive while a program is running during suspend. A design that acts on that resume at once would show bit 6 clear too early, or drop the program byte. The three error causes are driven one at a time and the block that was targeted is read back afterwards. This catches a design that sets the wrong cause bit, or one that erases even though it reports an error. Clear status is issued while suspended, which exposes a design that also clears the suspend bit.

// File: rtl/fec_pkg.sv
// Package: shared types and codes for the flash erase command controller.
// Assumes: 8-bit command bytes; status bit positions are fixed by the host software.
package fec_pkg;

    typedef enum logic [3:0] {
        CMD_READ_ARRAY, CMD_ERASE_SETUP, CMD_CONFIRM, CMD_SUSPEND, CMD_READ_STATUS,
        CMD_CLEAR_STATUS, CMD_PROGRAM, CMD_QUERY, CMD_CONFIG, CMD_OTHER
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ERASE_SETUP, ST_ERASING, ST_SUSPENDED, ST_PROG_SETUP, ST_PROGRAMMING
    } wsm_state_e;

    typedef enum logic [1:0] { RM_ARRAY, RM_STATUS, RM_QUERY } read_mode_e;

    localparam logic [7:0] CODE_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CODE_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CODE_CONFIRM      = 8'hD0;
    localparam logic [7:0] CODE_SUSPEND      = 8'hB0;
    localparam logic [7:0] CODE_READ_STATUS  = 8'h70;
    localparam logic [7:0] CODE_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CODE_PROGRAM      = 8'h40;
    localparam logic [7:0] CODE_QUERY        = 8'h98;
    localparam logic [7:0] CODE_CONFIG       = 8'hB8;
    localparam logic [7:0] QUERY_BYTE        = 8'h51;

endpackage

// File: rtl/fec_cmd_decode.sv
// Module: turns a raw command byte into a command enum.
// Assumes: bytes with no code of their own map to CMD_OTHER.
module fec_cmd_decode
    import fec_pkg::*;
(
    input  logic [7:0] code_i,
    output cmd_e       cmd_o
);

    // Purpose: look up the byte in the command code set.
    always_comb begin
        case (code_i)
            CODE_READ_ARRAY:   cmd_o = CMD_READ_ARRAY;
            CODE_ERASE_SETUP:  cmd_o = CMD_ERASE_SETUP;
            CODE_CONFIRM:      cmd_o = CMD_CONFIRM;
            CODE_SUSPEND:      cmd_o = CMD_SUSPEND;
            CODE_READ_STATUS:  cmd_o = CMD_READ_STATUS;
            CODE_CLEAR_STATUS: cmd_o = CMD_CLEAR_STATUS;
            CODE_PROGRAM:      cmd_o = CMD_PROGRAM;
            CODE_QUERY:        cmd_o = CMD_QUERY;
            CODE_CONFIG:       cmd_o = CMD_CONFIG;
            default:           cmd_o = CMD_OTHER;
        endcase
    end

endmodule

// File: rtl/fec_array.sv
// Module: behavioural byte array, organised in equal blocks.
// Assumes: an erase strobe fills one whole block with FFh in a single edge;
//          a program strobe overwrites one byte; erase wins if both hit a byte.
module fec_array #(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 8,
    localparam int NBYTES     = NUM_BLOCKS * BLOCK_BYTES,
    localparam int ADDR_W     = $clog2(NBYTES),
    localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_go_i,
    input  logic [BLK_W-1:0]  erase_blk_i,
    input  logic              prog_go_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    input  logic [7:0]        prog_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_byte_o
);

    logic [NBYTES*8-1:0] flat_w;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        localparam int unsigned G_BLK = g / BLOCK_BYTES;
        logic [7:0] byte_q;

        // Purpose: hold one array byte; reset to its own address, erase or program it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= 8'(g);
            else if (erase_go_i && erase_blk_i == BLK_W'(G_BLK))
                byte_q <= 8'hFF;
            else if (prog_go_i && prog_addr_i == ADDR_W'(g))
                byte_q <= prog_data_i;
        end

        assign flat_w[g*8 +: 8] = byte_q;

        // R2
        erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (erase_go_i && erase_blk_i == BLK_W'(G_BLK)) |=> byte_q == 8'hFF);
    end

    assign rd_byte_o = flat_w[{rd_addr_i, 3'b000} +: 8];

endmodule

// File: rtl/fec_wsm.sv
// Module: command sequencer and status register for erase, suspend and program.
// Assumes: at most one command per cycle; the confirm address selects the block;
//          a suspend on the last erase cycle is lost to the completion.
module fec_wsm
    import fec_pkg::*;
#(
    parameter int NUM_BLOCKS   = 4,
    parameter int ADDR_W       = 5,
    parameter int BLK_W        = 2,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 6,
    localparam int CNT_W       = $clog2(ERASE_CYCLES + 1),
    localparam int PCNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  cmd_e                  cmd_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [7:0]            wr_data_i,
    input  logic                  vpp_ok_i,
    input  logic                  hv_override_i,
    input  logic [NUM_BLOCKS-1:0] blk_lock_i,
    output logic [7:0]            status_o,
    output read_mode_e            read_mode_o,
    output logic                  erase_go_o,
    output logic [BLK_W-1:0]      erase_blk_o,
    output logic                  prog_go_o,
    output logic [ADDR_W-1:0]     prog_addr_o,
    output logic [7:0]            prog_data_o
);

    wsm_state_e        state_q, state_d;
    read_mode_e        rmode_q, rmode_d;
    logic              susp_q, susp_d, pend_q, pend_d;
    logic [3:0]        err_q, err_d;      // {erase, sequence, voltage, lock}
    logic [CNT_W-1:0]  ecnt_q, ecnt_d;
    logic [PCNT_W-1:0] pcnt_q, pcnt_d;
    logic [BLK_W-1:0]  eblk_q, eblk_d;
    logic [ADDR_W-1:0] paddr_q, paddr_d;
    logic [7:0]        pdata_q, pdata_d;
    logic [BLK_W-1:0]  wr_blk;
    logic              ready;

    assign wr_blk = wr_addr_i[ADDR_W-1 -: BLK_W];
    assign ready  = !(state_q == ST_ERASING || state_q == ST_PROGRAMMING);

    // Purpose: next-state, error and counter logic for every sequencer state.
    always_comb begin
        state_d = state_q; rmode_d = rmode_q; susp_d = susp_q; pend_d = pend_q;
        err_d = err_q; ecnt_d = ecnt_q; pcnt_d = pcnt_q; eblk_d = eblk_q;
        paddr_d = paddr_q; pdata_d = pdata_q;
        erase_go_o = 1'b0; prog_go_o = 1'b0;
        case (state_q)
            ST_IDLE, ST_SUSPENDED: begin
                if (wr_en_i) begin
                    case (cmd_i)
                        CMD_READ_ARRAY:   rmode_d = RM_ARRAY;
                        CMD_READ_STATUS:  rmode_d = RM_STATUS;
                        CMD_QUERY:        rmode_d = RM_QUERY;
                        CMD_CLEAR_STATUS: err_d = '0;
                        CMD_PROGRAM: begin
                            state_d = ST_PROG_SETUP; rmode_d = RM_STATUS;
                        end
                        CMD_ERASE_SETUP: if (state_q == ST_IDLE) begin
                            state_d = ST_ERASE_SETUP; rmode_d = RM_STATUS;
                        end
                        CMD_CONFIRM: if (state_q == ST_SUSPENDED) begin
                            state_d = ST_ERASING; susp_d = 1'b0; rmode_d = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ERASE_SETUP: begin
                if (wr_en_i) begin
                    rmode_d = RM_STATUS;
                    state_d = ST_IDLE;
                    if (cmd_i != CMD_CONFIRM)
                        err_d = err_q | 4'b1100;
                    else if (!vpp_ok_i)
                        err_d = err_q | 4'b1010;
                    else if (blk_lock_i[wr_blk] && !hv_override_i)
                        err_d = err_q | 4'b1001;
                    else begin
                        state_d = ST_ERASING;
                        eblk_d  = wr_blk;
                        ecnt_d  = CNT_W'(ERASE_CYCLES - 1);
                    end
                end
            end
            ST_ERASING: begin
                if (ecnt_q == '0) begin
                    erase_go_o = 1'b1;
                    state_d    = ST_IDLE;
                end else begin
                    ecnt_d = ecnt_q - CNT_W'(1);
                    if (wr_en_i && cmd_i == CMD_SUSPEND) begin
                        state_d = ST_SUSPENDED; susp_d = 1'b1;
                    end
                end
            end
            ST_PROG_SETUP: begin
                if (wr_en_i) begin
                    if (susp_q && wr_blk == eblk_q) begin
                        err_d   = err_q | 4'b0100;
                        state_d = ST_SUSPENDED;
                    end else begin
                        state_d = ST_PROGRAMMING;
                        paddr_d = wr_addr_i;
                        pdata_d = wr_data_i;
                        pcnt_d  = PCNT_W'(PROG_CYCLES - 1);
                    end
                end
            end
            ST_PROGRAMMING: begin
                if (wr_en_i && cmd_i == CMD_CONFIRM && susp_q) pend_d = 1'b1;
                if (pcnt_q == '0) begin
                    prog_go_o = 1'b1;
                    if (!susp_q)
                        state_d = ST_IDLE;
                    else if (pend_d) begin
                        state_d = ST_ERASING; susp_d = 1'b0; pend_d = 1'b0;
                    end else
                        state_d = ST_SUSPENDED;
                end else
                    pcnt_d = pcnt_q - PCNT_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: register the sequencer state with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; rmode_q <= RM_ARRAY; susp_q <= 1'b0; pend_q <= 1'b0;
            err_q <= '0; ecnt_q <= '0; pcnt_q <= '0; eblk_q <= '0;
            paddr_q <= '0; pdata_q <= '0;
        end else begin
            state_q <= state_d; rmode_q <= rmode_d; susp_q <= susp_d; pend_q <= pend_d;
            err_q <= err_d; ecnt_q <= ecnt_d; pcnt_q <= pcnt_d; eblk_q <= eblk_d;
            paddr_q <= paddr_d; pdata_q <= pdata_d;
        end
    end

    assign status_o    = {ready, susp_q, err_q[3], err_q[2], err_q[1], 1'b0, err_q[0], 1'b0};
    assign read_mode_o = rmode_q;
    assign erase_blk_o = eblk_q;
    assign prog_addr_o = paddr_q;
    assign prog_data_o = pdata_q;

    // R5
    seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE_SETUP && wr_en_i && cmd_i != CMD_CONFIRM)
        |=> status_o[5] && status_o[4] && state_q == ST_IDLE);

    // R6
    vpp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE_SETUP && wr_en_i && cmd_i == CMD_CONFIRM && !vpp_ok_i)
        |=> status_o[5] && status_o[3] && state_q != ST_ERASING);

    // R7
    lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE_SETUP && wr_en_i && cmd_i == CMD_CONFIRM && vpp_ok_i
         && blk_lock_i[wr_blk] && !hv_override_i)
        |=> status_o[5] && status_o[1] && state_q != ST_ERASING);

    // R8
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASING && ecnt_q != '0 && wr_en_i && cmd_i == CMD_SUSPEND)
        |=> status_o[7:6] == 2'b11 && ecnt_q == $past(ecnt_q) - CNT_W'(1));

    // R11
    resume_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROGRAMMING && susp_q && pcnt_q != '0)
        |=> state_q == ST_PROGRAMMING && status_o[6]);

    // R12
    clear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_SUSPENDED) && wr_en_i && cmd_i == CMD_CLEAR_STATUS)
        |=> status_o[5:3] == 3'b000 && !status_o[1] && status_o[6] == $past(status_o[6]));

endmodule

// File: rtl/flash_erase_ctrl.sv
// Module: top of the flash erase command controller; bus decode, sequencer, array
//         and the registered read path.
// Assumes: NUM_BLOCKS and BLOCK_BYTES are powers of two, NUM_BLOCKS >= 2.
module flash_erase_ctrl
    import fec_pkg::*;
#(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_BYTES  = 8,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 6,
    localparam int ADDR_W      = $clog2(NUM_BLOCKS * BLOCK_BYTES),
    localparam int BLK_W       = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [7:0]            bus_wdata_i,
    input  logic                  bus_rd_i,
    output logic [7:0]            bus_rdata_o,
    input  logic                  vpp_ok_i,
    input  logic                  hv_override_i,
    input  logic [NUM_BLOCKS-1:0] blk_lock_i,
    output logic                  sts_busy_o
);

    cmd_e              cmd;
    read_mode_e        rmode;
    logic [7:0]        status, arr_byte;
    logic              erase_go, prog_go;
    logic [BLK_W-1:0]  erase_blk;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;

    fec_cmd_decode u_dec (.code_i(bus_wdata_i), .cmd_o(cmd));

    fec_wsm #(
        .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .BLK_W(BLK_W),
        .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
    ) u_wsm (
        .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr_i), .cmd_i(cmd),
        .wr_addr_i(bus_addr_i), .wr_data_i(bus_wdata_i), .vpp_ok_i(vpp_ok_i),
        .hv_override_i(hv_override_i), .blk_lock_i(blk_lock_i),
        .status_o(status), .read_mode_o(rmode), .erase_go_o(erase_go),
        .erase_blk_o(erase_blk), .prog_go_o(prog_go), .prog_addr_o(prog_addr),
        .prog_data_o(prog_data)
    );

    fec_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .erase_go_i(erase_go), .erase_blk_i(erase_blk),
        .prog_go_i(prog_go), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
        .rd_addr_i(bus_addr_i), .rd_byte_o(arr_byte)
    );

    // Purpose: capture array, status or identification byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata_o <= '0;
        else if (bus_rd_i) begin
            case (rmode)
                RM_STATUS: bus_rdata_o <= status;
                RM_QUERY:  bus_rdata_o <= QUERY_BYTE;
                default:   bus_rdata_o <= arr_byte;
            endcase
        end
    end

    assign sts_busy_o = ~status[7];

endmodule

// File: tb/flash_erase_ctrl_tb.sv
`timescale 1ns/1ps
module flash_erase_ctrl_tb;

    localparam int NB = 4, BB = 8, EC = 20, PC = 4, AW = 5;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WAIT = 2'd2;
    localparam int NVEC = 24;
    // {op, addr, data/cycles, expected, requirement}
    localparam logic [30:0] VEC [NVEC] = '{
        {OP_RD,   5'd9,  8'h00, 8'h09, 8'd1},   // R1 array mode after reset
        {OP_WR,   5'd9,  8'h20, 8'h00, 8'd2},
        {OP_WR,   5'd9,  8'hD0, 8'h00, 8'd2},
        {OP_WAIT, 5'd0,  8'd22, 8'h00, 8'd2},
        {OP_RD,   5'd0,  8'h00, 8'h80, 8'd4},   // R4 R3 status mode, ready
        {OP_WR,   5'd0,  8'hFF, 8'h00, 8'd3},
        {OP_RD,   5'd9,  8'h00, 8'hFF, 8'd2},   // R2
        {OP_RD,   5'd8,  8'h00, 8'hFF, 8'd2},
        {OP_RD,   5'd15, 8'h00, 8'hFF, 8'd2},
        {OP_RD,   5'd16, 8'h00, 8'h10, 8'd2},
        {OP_RD,   5'd7,  8'h00, 8'h07, 8'd2},
        {OP_WR,   5'd0,  8'h20, 8'h00, 8'd5},
        {OP_WR,   5'd0,  8'hFF, 8'h00, 8'd5},
        {OP_RD,   5'd0,  8'h00, 8'hB0, 8'd5},   // R5 bits 5,4
        {OP_WR,   5'd0,  8'hFF, 8'h00, 8'd5},
        {OP_RD,   5'd0,  8'h00, 8'h00, 8'd5},   // R5 no erase
        {OP_WR,   5'd0,  8'h70, 8'h00, 8'd12},
        {OP_RD,   5'd0,  8'h00, 8'hB0, 8'd12},  // R12 errors persist
        {OP_WR,   5'd0,  8'h50, 8'h00, 8'd12},
        {OP_RD,   5'd0,  8'h00, 8'h80, 8'd12},  // R12 cleared
        {OP_WR,   5'd0,  8'h98, 8'h00, 8'd3},
        {OP_RD,   5'd0,  8'h00, 8'h51, 8'd3},   // R3 identification
        {OP_WR,   5'd0,  8'hFF, 8'h00, 8'd3},
        {OP_RD,   5'd1,  8'h00, 8'h01, 8'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr = 1'b0, rd = 1'b0, vpp = 1'b1, hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [NB-1:0] lock = '0;
    logic busy;
    int total = 0, bad = 0, cnt;
    logic [7:0] got;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_erase_ctrl #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rd_i(rd), .bus_rdata_o(rdata), .vpp_ok_i(vpp), .hv_override_i(hv),
        .blk_lock_i(lock), .sts_busy_o(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 busy after reset", int'(busy), 0);

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][30:29])
                OP_WR:   bus_wr(VEC[i][28:24], VEC[i][23:16]);
                OP_RD: begin
                    bus_rd(VEC[i][28:24], got);
                    check($sformatf("R%0d table %0d", VEC[i][7:0], i), int'(got), int'(VEC[i][15:8]));
                end
                default: repeat (int'(VEC[i][23:16])) @(negedge clk);
            endcase
        end

        // R2 R4: busy lasts exactly EC cycles
        bus_wr(5'd0, 8'h20); bus_wr(5'd0, 8'hD0);
        count_busy(cnt);
        check("R2 erase busy cycles", cnt, EC);
        bus_rd(5'd0, got); check("R4 ready after erase", int'(got), 8'h80);

        // R13: command during erase ignored, reads stay status
        bus_wr(5'd0, 8'h20); bus_wr(5'd0, 8'hD0);
        bus_wr(5'd0, 8'hFF);
        bus_rd(5'd0, got); check("R13 status while erasing", int'(got), 8'h00);
        count_busy(cnt);
        bus_rd(5'd0, got); check("R3 status after erase", int'(got), 8'h80);

        // R6: voltage error, block 2 untouched
        vpp = 1'b0;
        bus_wr(5'd16, 8'h20); bus_wr(5'd16, 8'hD0);
        check("R6 no busy", int'(busy), 0);
        bus_rd(5'd0, got); check("R6 status", int'(got), 8'hA8);
        vpp = 1'b1;
        bus_wr(5'd0, 8'h50); bus_wr(5'd0, 8'hFF);
        bus_rd(5'd16, got); check("R6 array kept", int'(got), 8'h10);

        // R7: lock error, then override
        lock = 4'b1000;
        bus_wr(5'd24, 8'h20); bus_wr(5'd24, 8'hD0);
        bus_rd(5'd0, got); check("R7 lock status", int'(got), 8'hA2);
        bus_wr(5'd0, 8'h50); bus_wr(5'd0, 8'hFF);
        bus_rd(5'd24, got); check("R7 locked kept", int'(got), 8'h18);
        hv = 1'b1;
        bus_wr(5'd24, 8'h20); bus_wr(5'd24, 8'hD0);
        count_busy(cnt);
        bus_rd(5'd0, got); check("R7 override status", int'(got), 8'h80);
        bus_wr(5'd0, 8'hFF);
        bus_rd(5'd24, got); check("R7 override erased", int'(got), 8'hFF);
        hv = 1'b0; lock = '0;

        // R8 R9 R10: suspend block 2, program block 0, resume
        bus_wr(5'd16, 8'h20); bus_wr(5'd16, 8'hD0);
        repeat (4) @(negedge clk);
        bus_wr(5'd16, 8'hB0);
        check("R8 ready on suspend", int'(busy), 0);
        bus_rd(5'd0, got); check("R8 suspend status", int'(got), 8'hC0);
        bus_wr(5'd0, 8'h20);
        bus_rd(5'd0, got); check("R9 setup ignored in suspend", int'(got), 8'hC0);
        bus_wr(5'd0, 8'hFF);
        bus_rd(5'd9, got); check("R9 read other block", int'(got), 8'hFF);
        bus_wr(5'd2, 8'h40); bus_wr(5'd2, 8'h5A);
        count_busy(cnt);
        check("R9 program busy cycles", cnt, PC);
        bus_rd(5'd0, got); check("R9 back to suspend", int'(got), 8'hC0);
        bus_wr(5'd0, 8'hFF);
        bus_rd(5'd2, got); check("R9 programmed byte", int'(got), 8'h5A);
        bus_wr(5'd18, 8'h40); bus_wr(5'd18, 8'h33);
        bus_rd(5'd0, got); check("R9 program to suspended block", int'(got), 8'hD0);
        bus_wr(5'd0, 8'h50);
        bus_rd(5'd0, got); check("R12 clear keeps suspend", int'(got), 8'hC0);
        bus_wr(5'd16, 8'hD0);
        check("R10 busy on resume", int'(busy), 1);
        count_busy(cnt);
        check("R10 remaining erase cycles", cnt, EC - 5);
        bus_wr(5'd0, 8'hFF);
        bus_rd(5'd18, got); check("R10 block erased", int'(got), 8'hFF);
        bus_rd(5'd2, got); check("R10 other block kept", int'(got), 8'h5A);

        // R11: resume during program in suspend waits for program
        bus_wr(5'd8, 8'h20); bus_wr(5'd8, 8'hD0);
        bus_wr(5'd8, 8'hB0);
        bus_wr(5'd3, 8'h40); bus_wr(5'd3, 8'h77);
        bus_wr(5'd0, 8'hD0);
        bus_rd(5'd0, got); check("R11 still suspended", int'(got), 8'h40);
        count_busy(cnt);
        check("R11 continuous busy", cnt, EC + 1);
        bus_rd(5'd0, got); check("R11 final status", int'(got), 8'h80);
        bus_wr(5'd0, 8'hFF);
        bus_rd(5'd3, got); check("R11 program kept", int'(got), 8'h77);
        bus_rd(5'd12, got); check("R11 erase finished", int'(got), 8'hFF);

        summary();
    end

endmodule